// File: doc/BRIEF.md
# Keyed Hibernate Entry Controller

This block holds one 32-bit control word. Firmware writes it to move the chip into a hibernate state. Entry is guarded in three ways. A key byte must already hold the value 0x3A. Firmware must first write a freeze step and then a hibernate step, in that order. A write-once lock bit can shut the word against all later writes until reset. A firmware token byte stays unchanged across hibernate and wake. Firmware reads it after wake to tell a wake apart from a cold start.

Wake events come in on a vector of inputs. They are captured into a sticky cause register. A sensing-mode bit decides whether capture happens only while in hibernate or in every mode. When an enabled cause is pending, the block raises a wake request and leaves hibernate. A cause that was already pending at entry forces an immediate exit, so no wake event is lost. The freeze stays in force after wake until firmware clears it.

Top module: `hib_seq_ctrl`

## Requirements
- R1: After `rst`, the readback word is zero and `io_prep`, `io_freeze`, `hib_enter`, `cause_q` and `wake` are all low.
- R2: The held key byte (bits 15:8, value before the write) must equal 0x3A for a freeze write to raise `io_freeze` or for a hibernate write to enter. With any other held key, `io_freeze` and `hib_enter` do not rise.
- R3: A write with bit 17 set raises `io_prep` and the readback bit 17 whatever the key. `io_freeze` rises only on a later bit-17 write, made while `io_prep` is already high and the key is valid. A write with bit 17 clear lowers both.
- R4: A write with bit 31 set enters hibernate (`hib_enter` high, readback bit 31 set) only when `io_freeze` was already high. From reset, a write that sets bits 17 and 31 together only raises `io_prep`.
- R5: Once a write sets bit 30, every later write is ignored and the readback word stays unchanged until a reset clears it.
- R6: The token byte (bits 7:0) keeps its value through hibernate entry and wake. `rst` clears it.
- R7: `soft_rst` clears the word, the freeze outputs and the cause register when readback bit 17 is 0. It has no effect while that bit is 1.
- R8: With bit 29 at 0, a wake event sets its cause bit only while in hibernate. With bit 29 at 1, it sets the cause bit in any mode.
- R9: `wake` is the OR over all bits of `cause_q & wake_mask`. While in hibernate, a high `wake` clears `hib_enter` at the next edge, and `io_freeze` and the token stay unchanged.
- R10: A cycle with `cause_clr_en` high clears each cause bit whose `cause_clr` bit is 1.
- R11: With bit 29 at 1, an enabled cause that is already pending when hibernate is entered makes `hib_enter` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high, clears everything |
| soft_rst | input | 1 | Internal reset, honoured only while freeze is clear |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| wake_evt | input | N_WAKE | Wake event inputs |
| wake_mask | input | N_WAKE | Enable mask for the wake causes |
| cause_clr_en | input | 1 | Strobe for clearing cause bits |
| cause_clr | input | N_WAKE | Write-1-to-clear pattern for the cause bits |
| cause_q | output | N_WAKE | Sticky wake cause bits |
| io_prep | output | 1 | Freeze-prepare notice to deep-sleep peripherals |
| io_freeze | output | 1 | IO freeze in force |
| hib_enter | output | 1 | Hibernate state |
| wake | output | 1 | Wake request |

## Verification
Each control-word write is registered, so its effect on `rd_data`, `io_prep`, `io_freeze` and `hib_enter` shows one edge later. The bench drives on a falling edge and checks on the next falling edge. A wake event reaches `cause_q` and `wake` one edge after it is sampled. The exit from hibernate takes one further edge, so the bench checks that `hib_enter` is still high half a cycle after the event edge and low one cycle later. The one-cycle hibernate pulse from a pending cause is checked at two successive falling edges, which tests both its rise and its fall.

// File: rtl/hib_pkg.sv
package hib_pkg;
  localparam int WORD_W   = 32;
  localparam int TOK_LSB  = 0;
  localparam int TOK_W    = 8;
  localparam int KEY_LSB  = 8;
  localparam int KEY_W    = 8;
  localparam int FRZ_BIT  = 17;
  localparam int SNS_BIT  = 29;
  localparam int LCK_BIT  = 30;
  localparam int HIB_BIT  = 31;

  typedef struct packed {
    logic             hib;
    logic             lock;
    logic             sense;
    logic             frz;
    logic [KEY_W-1:0] key;
    logic [TOK_W-1:0] tok;
  } hib_word_t;

  function automatic hib_word_t unpack_word(input logic [WORD_W-1:0] d);
    hib_word_t w;
    w.hib   = d[HIB_BIT];
    w.lock  = d[LCK_BIT];
    w.sense = d[SNS_BIT];
    w.frz   = d[FRZ_BIT];
    w.key   = d[KEY_LSB +: KEY_W];
    w.tok   = d[TOK_LSB +: TOK_W];
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input hib_word_t w);
    logic [WORD_W-1:0] d;
    d = '0;
    d[HIB_BIT] = w.hib;
    d[LCK_BIT] = w.lock;
    d[SNS_BIT] = w.sense;
    d[FRZ_BIT] = w.frz;
    d[KEY_LSB +: KEY_W] = w.key;
    d[TOK_LSB +: TOK_W] = w.tok;
    return d;
  endfunction
endpackage

// File: rtl/hib_ctrl_reg.sv
module hib_ctrl_reg
  import hib_pkg::*;
#(
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wake_req,
  output hib_word_t         word_q,
  output logic              frz_q
);
  hib_word_t wd;
  logic      key_ok;

  assign wd     = unpack_word(wr_data);
  assign key_ok = (word_q.key == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst || sclr) begin
      word_q <= '0;
      frz_q  <= 1'b0;
    end else begin
      if (wr_en && !word_q.lock) begin
        word_q.tok   <= wd.tok;
        word_q.key   <= wd.key;
        word_q.sense <= wd.sense;
        word_q.lock  <= wd.lock;
        if (wd.frz) begin
          word_q.frz <= 1'b1;
          if (word_q.frz && key_ok) frz_q <= 1'b1;
        end else begin
          word_q.frz <= 1'b0;
          frz_q      <= 1'b0;
        end
        if (wd.hib && key_ok && frz_q) word_q.hib <= 1'b1;
      end
      if (word_q.hib && wake_req) word_q.hib <= 1'b0;
    end
  end
endmodule

// File: rtl/hib_wake_latch.sv
module hib_wake_latch #(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclr,
  input  logic              sense_all,
  input  logic              in_hib,
  input  logic [N_WAKE-1:0] evt,
  input  logic              clr_en,
  input  logic [N_WAKE-1:0] clr,
  output logic [N_WAKE-1:0] cause
);
  logic arm;
  assign arm = sense_all | in_hib;

  for (genvar i = 0; i < N_WAKE; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || sclr)
        cause[i] <= 1'b0;
      else
        cause[i] <= (cause[i] & ~(clr_en & clr[i])) | (evt[i] & arm);
    end
  end
endmodule

// File: rtl/hib_seq_ctrl.sv
module hib_seq_ctrl
  import hib_pkg::*;
#(
  parameter int                N_WAKE     = 4,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic [N_WAKE-1:0] wake_mask,
  input  logic              cause_clr_en,
  input  logic [N_WAKE-1:0] cause_clr,
  output logic [N_WAKE-1:0] cause_q,
  output logic              io_prep,
  output logic              io_freeze,
  output logic              hib_enter,
  output logic              wake
);
  hib_word_t word_q;
  logic      sclr;

  assign sclr = soft_rst & ~word_q.frz;

  hib_ctrl_reg #(.UNLOCK_KEY(UNLOCK_KEY)) u_reg (
    .clk(clk), .rst(rst), .sclr(sclr), .wr_en(wr_en), .wr_data(wr_data),
    .wake_req(wake), .word_q(word_q), .frz_q(io_freeze)
  );

  hib_wake_latch #(.N_WAKE(N_WAKE)) u_wake (
    .clk(clk), .rst(rst), .sclr(sclr), .sense_all(word_q.sense),
    .in_hib(word_q.hib), .evt(wake_evt), .clr_en(cause_clr_en),
    .clr(cause_clr), .cause(cause_q)
  );

  assign wake      = |(cause_q & wake_mask);
  assign rd_data   = pack_word(word_q);
  assign io_prep   = word_q.frz;
  assign hib_enter = word_q.hib;
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk #(
  parameter int N_WAKE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [31:0]       rd_data,
  input logic              io_freeze,
  input logic              hib_enter,
  input logic              wake
);
  a_r2_bad_key_no_freeze: assert property (@(posedge clk) disable iff (rst)
    (!io_freeze && rd_data[15:8] != 8'h3A) |=> !io_freeze);

  a_r3_freeze_after_prep: assert property (@(posedge clk) disable iff (rst)
    (!io_freeze && !rd_data[17]) |=> !io_freeze);

  a_r4_entry_needs_freeze: assert property (@(posedge clk) disable iff (rst)
    (!hib_enter && !io_freeze) |=> !hib_enter);

  a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (rd_data[30] && !soft_rst && !hib_enter) |=> $stable(rd_data));

  a_r9_wake_exits: assert property (@(posedge clk) disable iff (rst)
    (hib_enter && wake) |=> !hib_enter);

  a_r7_soft_ignored: assert property (@(posedge clk) disable iff (rst)
    (rd_data[17] && soft_rst) |=> rd_data[17]);
endmodule

bind hib_seq_ctrl hib_seq_chk #(.N_WAKE(N_WAKE)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .rd_data(rd_data),
  .io_freeze(io_freeze), .hib_enter(hib_enter), .wake(wake)
);

// File: tb/sim_hib_seq_ctrl.sv
module sim_hib_seq_ctrl;
  localparam int NW = 4;
  logic clk = 0, rst = 1, soft_rst = 0, wr_en = 0, cause_clr_en = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NW-1:0] wake_evt = '0, wake_mask = '0, cause_clr = '0, cause_q;
  logic io_prep, io_freeze, hib_enter, wake;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hib_seq_ctrl #(.N_WAKE(NW)) u0 (.*);

  // {data, exp_prep, exp_freeze, exp_hib}
  localparam logic [34:0] VEC [7] = '{
    {32'h8002_3A00, 3'b100},  // R4 combined first write only preps
    {32'h8002_3A00, 3'b110},  // R3 second freeze with key
    {32'h0000_1100, 3'b000},  // R3 freeze clear
    {32'h0002_1100, 3'b100},  // R3 prep regardless of key
    {32'h0002_3A00, 3'b100},  // R2 held key wrong: no freeze
    {32'h0002_3A5A, 3'b110},  // R2 key now held: freeze
    {32'h8002_3A5A, 3'b111}   // R4 entry
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic evt(input logic [NW-1:0] e);
    @(negedge clk); wake_evt = e;
    @(negedge clk); wake_evt = '0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rd", rd_data, 0);
    check("R1 outs", {io_prep, io_freeze, hib_enter, wake, cause_q}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [31:0] d; logic [2:0] e;
      d = VEC[i][34:3]; e = VEC[i][2:0];
      wr(d);
      check("R2/R3/R4 outs", {io_prep, io_freeze, hib_enter}, e);
      check("R3/R4 rd", rd_data,
            (d & 32'h6000_FFFF) | (32'(e[2]) << 17) | (32'(e[0]) << 31));
    end

    // R8/R9/R6: sense 0, in hibernate, enabled event wakes
    wake_mask = 4'b0001;
    evt(4'b0001);
    check("R8 cause in hib", cause_q, 4'b0001);
    check("R9 wake", wake, 1);
    check("R9 hib still high", hib_enter, 1);
    @(negedge clk);
    check("R9 hib cleared", hib_enter, 0);
    check("R9 freeze kept", io_freeze, 1);
    check("R6 token kept", rd_data[7:0], 8'h5A);

    // R10
    @(negedge clk); cause_clr_en = 1; cause_clr = 4'b0001;
    @(negedge clk); cause_clr_en = 0; cause_clr = '0;
    check("R10 cleared", cause_q, 0);
    check("R10 wake low", wake, 0);

    // R7
    pulse_soft();
    check("R7 ignored", rd_data, 32'h0002_3A5A);
    check("R7 freeze kept", io_freeze, 1);
    wr(32'h0000_3A5A);
    pulse_soft();
    check("R7 cleared", rd_data, 0);
    check("R7 outs", {io_prep, io_freeze}, 0);

    // R8 sense modes outside hibernate
    evt(4'b0010);
    check("R8 sense0 no capture", cause_q, 0);
    wr(32'h2000_0000);
    evt(4'b0010);
    check("R8 sense1 capture", cause_q, 4'b0010);
    check("R9 masked", wake, 0);
    wake_mask = 4'b0010;
    #1 check("R9 unmasked", wake, 1);

    // R11 pending before entry
    wr(32'h2002_3A00);
    wr(32'h2002_3A00);
    check("R11 frozen", io_freeze, 1);
    wr(32'hA002_3A00);
    check("R11 entered", hib_enter, 1);
    @(negedge clk);
    check("R11 exit", hib_enter, 0);
    check("R11 freeze kept", io_freeze, 1);

    // R5 lockout
    wr(32'h4000_0077);
    check("R5 locked rd", rd_data, 32'h4000_0077);
    wr(32'h0002_3A00);
    check("R5 ignored rd", rd_data, 32'h4000_0077);
    check("R5 ignored prep", io_prep, 0);
    pulse_soft();
    check("R5 reset unlocks", rd_data, 0);

    // R6 rst clears token
    wr(32'h0000_00C3);
    check("R6 token written", rd_data[7:0], 8'hC3);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R6 token cleared", rd_data, 0);
    check("R1 cause cleared", cause_q, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule